// File: doc/BRIEF.md
# Dual-Channel Sync Selector and Conditioner

This block sits between two identical sync-processing channels and a downstream video timing core. Each channel delivers a horizontal sync, a vertical sync, a flag saying whether its sync is embedded in a composite signal, and a flag saying whether the channel is free-running. The block picks one channel and conditions its syncs for the timing core.

The choice is either fixed by a preference bit (manual mode) or made automatically (auto mode). In auto mode the preferred channel is used while it is locked, with a fallback to the other channel. When both channels are free-running, the block stays on the preferred channel and raises a free-run flag.

Every channel's HS and VS first pass through a glitch filter that drops short level changes. For composite sources the vertical sync is recovered by slicing long pulses out of the filtered HS line. For separate-sync sources the filtered VS line is used directly. A change of channel is held back until the newly requested channel's filtered HS begins a pulse, so no sync pulse is cut short. All sync polarities are active-high.

Top module: `dual_sync_selector`

## Requirements
- R1: While reset is asserted and right after it is released, `hs_out`, `vs_out`, `freerun_out` and `sel_ch2` are all 0, so channel 1 is the committed channel.
- R2: With `auto_mode` = 0, the requested channel is channel 1 when `prefer_ch1` = 1 and channel 2 when `prefer_ch1` = 0. The free-run inputs have no effect on the choice.
- R3: With `auto_mode` = 1, the requested channel is the preferred one if it is not free-running. Otherwise it is the other channel if that one is not free-running. Otherwise it is the preferred one.
- R4: `freerun_out` is registered one cycle after the inputs. In auto mode it is 1 exactly when both channels are free-running. In manual mode it copies the free-run input of the requested channel.
- R5: A level change on a channel's HS or VS that lasts fewer than FILT_LEN clock cycles (default 4) never reaches the outputs. A pulse lasting at least FILT_LEN cycles reaches the output with the same width.
- R6: A rising HS level on the committed channel, first sampled at clock edge N, appears on `hs_out` at edge N+FILT_LEN. It is not yet visible at edge N+FILT_LEN-1.
- R7: A change of requested channel is committed, and `sel_ch2` changes (1 = channel 2), only in the cycle where the requested channel's filtered HS rises. The first pulse from the new channel reaches `hs_out` at its full width.
- R8: When the committed channel's embedded flag is 0, `vs_out` follows that channel's filtered VS. Glitches shorter than FILT_LEN do not reach it.
- R9: When the committed channel's embedded flag is 1, `vs_out` comes from the slicer and the channel's VS input is ignored. The slicer output rises once a filtered HS pulse has been high for SLICE_LEN cycles (default 32). It falls when a filtered HS pulse shorter than SLICE_LEN ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ch1_hs | input | 1 | Channel 1 horizontal sync (or composite sync), active-high |
| ch1_vs | input | 1 | Channel 1 vertical sync, active-high |
| ch1_emb | input | 1 | Channel 1 carries embedded composite sync |
| ch1_freerun | input | 1 | Channel 1 is free-running (not locked) |
| ch2_hs | input | 1 | Channel 2 horizontal sync (or composite sync), active-high |
| ch2_vs | input | 1 | Channel 2 vertical sync, active-high |
| ch2_emb | input | 1 | Channel 2 carries embedded composite sync |
| ch2_freerun | input | 1 | Channel 2 is free-running (not locked) |
| auto_mode | input | 1 | 1 = automatic selection from free-run status |
| prefer_ch1 | input | 1 | 1 = channel 1 preferred or fixed, 0 = channel 2 |
| hs_out | output | 1 | Conditioned horizontal sync to the timing core |
| vs_out | output | 1 | Conditioned vertical sync to the timing core |
| freerun_out | output | 1 | Free-run indication for the selection |
| sel_ch2 | output | 1 | Committed channel: 0 = channel 1, 1 = channel 2 |

## Verification
The hardest situation to reach is a channel change, because the request alone does nothing visible. The bench first changes the request on a quiet line and confirms `sel_ch2` holds. It then drives an HS pulse on the requested channel only. The scoreboard confirms that this pulse comes out at full width and that the committed channel has flipped. The auto-mode table is covered by driving identical HS pulses on both channels after each free-run combination, so whichever channel is requested can commit.

// File: rtl/dss_pkg.sv
package dss_pkg;
  localparam int unsigned NCH = 2;

  typedef enum logic {
    SEL_CH1 = 1'b0,
    SEL_CH2 = 1'b1
  } ch_sel_e;

  typedef struct packed {
    logic hs;
    logic vs;
    logic emb;
    logic freerun;
  } ch_in_t;
endpackage

// File: rtl/dss_glitch_filter.sv
// Passes a level only after it has been seen on HOLD consecutive samples.
module dss_glitch_filter #(
  parameter int unsigned HOLD = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  localparam int unsigned CW = (HOLD > 1) ? $clog2(HOLD) : 1;
  localparam logic [CW-1:0] LAST = CW'(HOLD - 1);

  logic          q_r, q_n;
  logic [CW-1:0] cnt_r, cnt_n;
  logic          cnt_en;

  always_comb begin
    q_n    = q_r;
    cnt_n  = '0;
    cnt_en = 1'b1;
    if (din != q_r) begin
      if (cnt_r == LAST) begin
        q_n = din;
      end else begin
        cnt_n = cnt_r + 1'b1;
      end
    end else if (cnt_r == '0) begin
      cnt_en = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_r   <= 1'b0;
      cnt_r <= '0;
    end else begin
      q_r <= q_n;
      if (cnt_en) cnt_r <= cnt_n;
    end
  end

  assign dout = q_r;

  // R5: a new output level must have been present at the input
  p_level_from_input_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(q_r) |-> ($past(din) == q_r));
endmodule

// File: rtl/dss_arbiter.sv
// Works out which channel should drive the outputs and whether that is a free-run case.
module dss_arbiter
  import dss_pkg::*;
(
  input  logic           auto_mode,
  input  logic           prefer_ch1,
  input  logic [NCH-1:0] freerun,
  output ch_sel_e        req_ch,
  output logic           req_fr
);
  ch_sel_e pref_ch, alt_ch;
  logic    pref_fr, alt_fr;

  always_comb begin
    pref_ch = prefer_ch1 ? SEL_CH1 : SEL_CH2;
    alt_ch  = prefer_ch1 ? SEL_CH2 : SEL_CH1;
    pref_fr = prefer_ch1 ? freerun[0] : freerun[1];
    alt_fr  = prefer_ch1 ? freerun[1] : freerun[0];

    if (!auto_mode) begin
      req_ch = pref_ch;
      req_fr = pref_fr;
    end else if (!pref_fr) begin
      req_ch = pref_ch;
      req_fr = 1'b0;
    end else if (!alt_fr) begin
      req_ch = alt_ch;
      req_fr = 1'b0;
    end else begin
      req_ch = pref_ch;
      req_fr = 1'b1;
    end
  end
endmodule

// File: rtl/dss_vslicer.sv
// Recovers vertical sync from a composite line by measuring pulse lengths.
module dss_vslicer #(
  parameter int unsigned SLICE_LEN = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic csync,
  output logic vs
);
  localparam int unsigned CW = $clog2(SLICE_LEN + 1);
  localparam logic [CW-1:0] LIMIT = CW'(SLICE_LEN);
  localparam logic [CW-1:0] ALMOST = CW'(SLICE_LEN - 1);

  logic [CW-1:0] cnt_r, cnt_n;
  logic          vs_r, vs_n;
  logic          prev_r;

  always_comb begin
    cnt_n = cnt_r;
    vs_n  = vs_r;
    if (csync) begin
      if (cnt_r != LIMIT) cnt_n = cnt_r + 1'b1;
      if (cnt_r == ALMOST) vs_n = 1'b1;
    end else begin
      cnt_n = '0;
      if (prev_r && (cnt_r < LIMIT)) vs_n = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_r  <= '0;
      vs_r   <= 1'b0;
      prev_r <= 1'b0;
    end else begin
      cnt_r  <= cnt_n;
      vs_r   <= vs_n;
      prev_r <= csync;
    end
  end

  assign vs = vs_r;

  // R9: the sliced VS can only start inside an active composite pulse
  p_rise_inside_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(vs_r) |-> $past(csync));

  // R9: the sliced VS can only end right after a composite pulse finished
  p_fall_after_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(vs_r) |-> ($past(prev_r) && !$past(csync)));
endmodule

// File: rtl/dual_sync_selector.sv
module dual_sync_selector
  import dss_pkg::*;
#(
  parameter int unsigned FILT_LEN  = 4,
  parameter int unsigned SLICE_LEN = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ch1_hs,
  input  logic ch1_vs,
  input  logic ch1_emb,
  input  logic ch1_freerun,
  input  logic ch2_hs,
  input  logic ch2_vs,
  input  logic ch2_emb,
  input  logic ch2_freerun,
  input  logic auto_mode,
  input  logic prefer_ch1,
  output logic hs_out,
  output logic vs_out,
  output logic freerun_out,
  output logic sel_ch2
);
  // Reset: asynchronous assert, two-stage synchronous release
  logic [1:0] rst_pipe;
  logic       rst_n_int;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_n_int = rst_pipe[1];

  // Per-channel bundles
  ch_in_t         chan [NCH];
  logic [NCH-1:0] fr_vec;
  logic [NCH-1:0] f_hs, f_vs;
  logic [NCH-1:0] f_hs_d;

  always_comb begin
    chan[0] = '{hs: ch1_hs, vs: ch1_vs, emb: ch1_emb, freerun: ch1_freerun};
    chan[1] = '{hs: ch2_hs, vs: ch2_vs, emb: ch2_emb, freerun: ch2_freerun};
    for (int i = 0; i < NCH; i++) fr_vec[i] = chan[i].freerun;
  end

  for (genvar g = 0; g < NCH; g++) begin : g_chan
    dss_glitch_filter #(.HOLD(FILT_LEN)) u_hs_filt (
      .clk   (clk),
      .rst_n (rst_n_int),
      .din   (chan[g].hs),
      .dout  (f_hs[g])
    );
    dss_glitch_filter #(.HOLD(FILT_LEN)) u_vs_filt (
      .clk   (clk),
      .rst_n (rst_n_int),
      .din   (chan[g].vs),
      .dout  (f_vs[g])
    );
  end

  // Selection request
  ch_sel_e req_ch;
  logic    req_fr;

  dss_arbiter u_arb (
    .auto_mode  (auto_mode),
    .prefer_ch1 (prefer_ch1),
    .freerun    (fr_vec),
    .req_ch     (req_ch),
    .req_fr     (req_fr)
  );

  // Commit of the request on the requested channel's filtered HS leading edge
  ch_sel_e cur_q, eff_ch;
  logic    req_idx, eff_idx, rise_req;
  logic    eff_emb, slicer_in, slicer_vs;
  logic    hs_n, vs_n;
  logic    hs_q, vs_q, fr_q;

  always_comb begin
    req_idx   = logic'(req_ch);
    rise_req  = f_hs[req_idx] & ~f_hs_d[req_idx];
    eff_ch    = rise_req ? req_ch : cur_q;
    eff_idx   = logic'(eff_ch);
    eff_emb   = chan[eff_idx].emb;
    slicer_in = f_hs[eff_idx];
    hs_n      = f_hs[eff_idx];
    vs_n      = eff_emb ? slicer_vs : f_vs[eff_idx];
  end

  dss_vslicer #(.SLICE_LEN(SLICE_LEN)) u_slicer (
    .clk   (clk),
    .rst_n (rst_n_int),
    .csync (slicer_in),
    .vs    (slicer_vs)
  );

  always_ff @(posedge clk or negedge rst_n_int) begin
    if (!rst_n_int) begin
      f_hs_d <= '0;
      cur_q  <= SEL_CH1;
      hs_q   <= 1'b0;
      vs_q   <= 1'b0;
      fr_q   <= 1'b0;
    end else begin
      f_hs_d <= f_hs;
      cur_q  <= eff_ch;
      hs_q   <= hs_n;
      vs_q   <= vs_n;
      fr_q   <= req_fr;
    end
  end

  assign hs_out      = hs_q;
  assign vs_out      = vs_q;
  assign freerun_out = fr_q;
  assign sel_ch2     = (cur_q == SEL_CH2);

  // R2: manual mode follows the preference bit
  p_manual_pick_r2: assert property (@(posedge clk) disable iff (!rst_n_int)
    !auto_mode |-> (req_ch == (prefer_ch1 ? SEL_CH1 : SEL_CH2)));

  // R3: in auto mode a locked preferred channel always wins
  p_auto_pref_locked_r3: assert property (@(posedge clk) disable iff (!rst_n_int)
    (auto_mode && prefer_ch1 && !ch1_freerun) |-> (req_ch == SEL_CH1));

  // R4: auto mode flags free run exactly when both channels are free-running
  p_freerun_both_r4: assert property (@(posedge clk) disable iff (!rst_n_int)
    (auto_mode && ch1_freerun && ch2_freerun) |=> freerun_out);
  p_freerun_clear_r4: assert property (@(posedge clk) disable iff (!rst_n_int)
    (auto_mode && !(ch1_freerun && ch2_freerun)) |=> !freerun_out);

  // R7: a commit always coincides with the start of an output HS pulse
  p_switch_at_hs_edge_r7: assert property (@(posedge clk) disable iff (!rst_n_int)
    !$stable(sel_ch2) |-> hs_out);
endmodule

// File: tb/dual_sync_selector_tb.sv
module dual_sync_selector_tb;
  localparam int FILT_LEN  = 4;
  localparam int SLICE_LEN = 32;

  logic clk = 1'b0;
  logic rst_n;
  logic ch1_hs, ch1_vs, ch1_emb, ch1_freerun;
  logic ch2_hs, ch2_vs, ch2_emb, ch2_freerun;
  logic auto_mode, prefer_ch1;
  logic hs_out, vs_out, freerun_out, sel_ch2;

  int n_chk  = 0;
  int n_fail = 0;
  int hw     = 0;
  bit done   = 1'b0;
  int exp_q[$];

  always #2 clk = ~clk;

  dual_sync_selector #(.FILT_LEN(FILT_LEN), .SLICE_LEN(SLICE_LEN)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .ch1_hs(ch1_hs), .ch1_vs(ch1_vs), .ch1_emb(ch1_emb), .ch1_freerun(ch1_freerun),
    .ch2_hs(ch2_hs), .ch2_vs(ch2_vs), .ch2_emb(ch2_emb), .ch2_freerun(ch2_freerun),
    .auto_mode(auto_mode), .prefer_ch1(prefer_ch1),
    .hs_out(hs_out), .vs_out(vs_out), .freerun_out(freerun_out), .sel_ch2(sel_ch2)
  );

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // Driver: one HS pulse on the chosen channels; expected output width goes to the scoreboard
  task automatic hs_pulse(input bit on1, input bit on2, input int w, input int gap, input bit lat);
    @(negedge clk);
    if (on1) ch1_hs = 1'b1;
    if (on2) ch2_hs = 1'b1;
    if (w >= FILT_LEN) exp_q.push_back(w);
    for (int i = 1; i <= w; i++) begin
      @(negedge clk);
      if (lat && i == FILT_LEN)     check("R6 hs_out before latency", hs_out, 0);
      if (lat && i == FILT_LEN + 1) check("R6 hs_out at latency", hs_out, 1);
    end
    ch1_hs = 1'b0;
    ch2_hs = 1'b0;
    idle(gap);
  endtask

  // Monitor: measure each output HS pulse and compare with the scoreboard
  always @(negedge clk) begin
    if (rst_n) begin
      if (hs_out) begin
        hw++;
      end else if (hw > 0) begin
        if (exp_q.size() == 0) check("R5 unexpected hs pulse", hw, 0);
        else                   check("R5 R7 hs pulse width", hw, exp_q.pop_front());
        hw = 0;
      end
    end
  end

  task automatic auto_case(input bit am, input bit p1, input bit f1, input bit f2,
                           input int exp_sel, input int exp_fr, input string tag);
    @(negedge clk);
    auto_mode = am; prefer_ch1 = p1; ch1_freerun = f1; ch2_freerun = f2;
    hs_pulse(1'b1, 1'b1, 10, 12, 1'b0);
    check({tag, " sel_ch2"}, sel_ch2, exp_sel);
    check("R4 freerun_out", freerun_out, exp_fr);
  endtask

  initial begin
    rst_n = 1'b0;
    ch1_hs = 0; ch1_vs = 0; ch1_emb = 0; ch1_freerun = 0;
    ch2_hs = 0; ch2_vs = 0; ch2_emb = 0; ch2_freerun = 0;
    auto_mode = 0; prefer_ch1 = 1;
    idle(3);
    // R1: reset state
    check("R1 hs_out in reset", hs_out, 0);
    check("R1 vs_out in reset", vs_out, 0);
    check("R1 freerun_out in reset", freerun_out, 0);
    check("R1 sel_ch2 in reset", sel_ch2, 0);
    rst_n = 1'b1;
    idle(4);
    check("R1 sel_ch2 after reset", sel_ch2, 0);
    check("R1 hs_out after reset", hs_out, 0);

    // R6: latency, R5: glitch rejection and width
    hs_pulse(1'b1, 1'b0, 10, 10, 1'b1);
    hs_pulse(1'b1, 1'b0, 3, 10, 1'b0);
    hs_pulse(1'b1, 1'b0, 1, 10, 1'b0);
    hs_pulse(1'b1, 1'b0, 4, 10, 1'b0);
    hs_pulse(1'b1, 1'b0, 9, 10, 1'b0);

    // R8: separate sync, VS follows filtered VS
    @(negedge clk); ch1_vs = 1'b1;
    idle(FILT_LEN + 2);
    check("R8 vs_out follows vs", vs_out, 1);
    ch1_vs = 1'b0; idle(2); ch1_vs = 1'b1;
    idle(FILT_LEN + 4);
    check("R8 vs glitch rejected", vs_out, 1);
    ch1_vs = 1'b0;
    idle(FILT_LEN + 4);
    check("R8 vs_out released", vs_out, 0);

    // R9: embedded sync, VS from the slicer, VS input ignored
    @(negedge clk); ch1_emb = 1'b1; ch1_vs = 1'b1;
    for (int k = 0; k < 3; k++) hs_pulse(1'b1, 1'b0, 6, 30, 1'b0);
    check("R9 short pulses give no vs", vs_out, 0);
    hs_pulse(1'b1, 1'b0, SLICE_LEN + 8, 10, 1'b0);
    check("R9 vs set by broad pulse", vs_out, 1);
    hs_pulse(1'b1, 1'b0, SLICE_LEN + 8, 10, 1'b0);
    check("R9 vs held between broad pulses", vs_out, 1);
    hs_pulse(1'b1, 1'b0, 6, 30, 1'b0);
    check("R9 vs cleared by short pulse", vs_out, 0);
    ch1_emb = 1'b0; ch1_vs = 1'b0;
    idle(10);

    // R7: deferred switch to channel 2
    @(negedge clk); prefer_ch1 = 1'b0;
    idle(10);
    check("R7 no switch without hs edge", sel_ch2, 0);
    hs_pulse(1'b0, 1'b1, 12, 12, 1'b0);
    check("R7 switched after ch2 edge", sel_ch2, 1);
    @(negedge clk); prefer_ch1 = 1'b1;
    hs_pulse(1'b1, 1'b0, 8, 12, 1'b0);
    check("R7 back on ch1", sel_ch2, 0);

    // R2/R3/R4 selection table
    auto_case(1, 1, 0, 0, 0, 0, "R3 auto both locked");
    auto_case(1, 1, 1, 0, 1, 0, "R3 auto failover to ch2");
    auto_case(1, 1, 1, 1, 0, 1, "R3 auto both free pref ch1");
    auto_case(1, 0, 0, 1, 0, 0, "R3 auto failover to ch1");
    auto_case(1, 0, 0, 0, 1, 0, "R3 auto pref ch2 locked");
    auto_case(1, 0, 1, 1, 1, 1, "R3 auto both free pref ch2");
    auto_case(0, 1, 1, 0, 0, 1, "R2 manual ch1 ignores freerun");
    auto_case(0, 0, 0, 1, 1, 1, "R2 manual ch2 ignores freerun");
    auto_case(0, 0, 1, 0, 1, 0, "R2 manual ch2 locked");

    idle(20);
    check("R5 scoreboard drained", exp_q.size(), 0);
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    #(4 * 150000);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end
endmodule